// File: doc/BRIEF.md
# Time Base Capture Register

This block freezes the upper part of a free-running 20-bit PWM time base count into a read-only register. A capture is requested either by a rising edge on a hardware event input or by software writing a one into bit 0 at the capture address. Each capture sets a status flag. While the flag is set, the register is locked: every further request is discarded and the held count stays put.

Software collects the result through a small register bus. Reading the capture address returns the held count and clears the flag in the same action, which arms the register for the next event. Reading a second address returns a status word that carries the flag. Reading the status word does not disturb the flag. Read data is registered. It appears in the cycle after the read strobe and is zero in every other cycle.

Top module: `tbcap_capture_reg`

## Requirements
- R1: After a synchronous reset, `cap_flag` is 0, the held count is 0, and `bus_rdata` is 0.
- R2: While `cap_flag` is 0, a rising edge on `hw_evt` captures bits 19:4 of `tb_count` as sampled at that clock edge. `cap_flag` is 1 from the next cycle.
- R3: While `cap_flag` is 0, a write strobe to the capture address (`CAP_ADDR`, default 4'h4) with `bus_wdata[0]`=1 captures in the same way as R2. A write with bit 0 cleared, a write to any other address, and every other write data bit have no effect.
- R4: A read strobe at the capture address makes `bus_rdata` in the next cycle carry the held count in bits 19:4, with bits 3:0 and bits 31:20 zero. In any cycle that does not follow a read strobe, `bus_rdata` is 0.
- R5: A read strobe at the status address (`STAT_ADDR`, default 4'h0) returns the flag in bit 5 of `bus_rdata` in the next cycle, with every other bit zero.
- R6: A read of the capture address clears `cap_flag` from the next cycle. A read of the status address leaves it unchanged.
- R7: While `cap_flag` is 1, hardware and software capture requests are ignored, and the held count does not change.
- R8: A hardware edge and a software capture write in the same cycle while armed give a single capture of that cycle's count.
- R9: A capture request in the same cycle as a capture-address read while `cap_flag` is 1 is dropped. After that read, the flag stays 0 until a new request arrives.
- R10: `hw_evt` held high gives only one capture per rising edge, even across a read that re-arms the register.
- R11: A capture-address read in the same cycle as a request while armed returns the previously held count, and the new capture still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | DATA_W (32) | Write data; only bit 0 is used |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| tb_count | input | CNT_W (20) | Free-running time base count |
| hw_evt | input | 1 | Hardware capture event; its rising edges are used |
| cap_flag | output | 1 | Capture-available status flag |

## Verification
The stimulus covers several input patterns, and each one separates a different failure:

- **Isolated single-cycle hardware pulses.** These confirm that the captured field is aligned to the sampling edge.
- **Software writes with bit 0 set, cleared, or sent to the wrong address.** These separate a real decode of bit 0 from any write that merely lands at the address.
- **Request bursts while the flag is set.** These expose any leak through the lock.
- **Collisions of a request with a capture read, in both flag states.** These distinguish a dropped request from a request that re-captures or is deferred.
- **A hardware level held high across a re-arming read.** This tells edge detection apart from level sensing.

A behavioural model runs alongside the design and compares both outputs every cycle. Directed reads also check the exact captured word at each of these points.

// File: rtl/tbcap_pkg.sv
package tbcap_pkg;
  localparam int unsigned CNT_W  = 20;
  localparam int unsigned LSB    = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned FLD_W  = CNT_W - LSB;
  localparam int unsigned STAT_BIT = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CAP  = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/tbcap_edge_det.sv
module tbcap_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tbcap_hold_core.sv
module tbcap_hold_core #(
  parameter int unsigned FLD_W = tbcap_pkg::FLD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             rd_clr,
  input  logic [FLD_W-1:0] cnt_hi,
  output logic             flag,
  output logic [FLD_W-1:0] hold
);
  logic take;

  assign take = req & ~flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      hold <= '0;
    end else if (flag) begin
      if (rd_clr) flag <= 1'b0;
    end else if (take) begin
      flag <= 1'b1;
      hold <= cnt_hi;
    end
  end

  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag && req) |=> (flag && hold == $past(cnt_hi)));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !rd_clr) |=> (flag && $stable(hold)));
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && rd_clr) |=> !flag);
  // R9
  drop_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && rd_clr && req) |=> (!flag && $stable(hold)));
endmodule

// File: rtl/tbcap_read_fmt.sv
module tbcap_read_fmt
  import tbcap_pkg::*;
#(
  parameter int unsigned DATA_W   = tbcap_pkg::DATA_W,
  parameter int unsigned FLD_W    = tbcap_pkg::FLD_W,
  parameter int unsigned LSB      = tbcap_pkg::LSB,
  parameter int unsigned STAT_BIT = tbcap_pkg::STAT_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  rd_sel_e           sel,
  input  logic [FLD_W-1:0]  hold,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cap_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] nxt;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bits
      if (b >= LSB && b < LSB + FLD_W) begin : g_fld
        assign cap_word[b] = hold[b-LSB];
      end else begin : g_zero
        assign cap_word[b] = 1'b0;
      end
      if (b == STAT_BIT) begin : g_st
        assign stat_word[b] = flag;
      end else begin : g_stz
        assign stat_word[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    nxt = '0;
    if (rd) begin
      unique case (sel)
        SEL_CAP:  nxt = cap_word;
        SEL_STAT: nxt = stat_word;
        default:  nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
  // R4
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_CAP) |=> (rdata[LSB-1:0] == '0 && rdata[LSB+:FLD_W] == $past(hold)));
  // R5
  stat_word_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_STAT) |=> (rdata == (DATA_W'($past(flag)) << STAT_BIT)));
endmodule

// File: rtl/tbcap_capture_reg.sv
module tbcap_capture_reg
  import tbcap_pkg::*;
#(
  parameter int unsigned        ADDR_W    = tbcap_pkg::ADDR_W,
  parameter int unsigned        DATA_W    = tbcap_pkg::DATA_W,
  parameter int unsigned        CNT_W     = tbcap_pkg::CNT_W,
  parameter int unsigned        LSB       = tbcap_pkg::LSB,
  parameter logic [ADDR_W-1:0]  CAP_ADDR  = 4'h4,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  tb_count,
  input  logic              hw_evt,
  output logic              cap_flag
);
  localparam int unsigned FW = CNT_W - LSB;

  logic          hw_rise;
  logic          sw_req;
  logic          rd_cap;
  logic          req;
  logic          flag;
  logic [FW-1:0] hold;
  rd_sel_e       sel;

  assign sw_req = bus_wr & (bus_addr == CAP_ADDR) & bus_wdata[0];
  assign rd_cap = bus_rd & (bus_addr == CAP_ADDR);
  assign req    = hw_rise | sw_req;

  always_comb begin
    if (bus_addr == CAP_ADDR)       sel = SEL_CAP;
    else if (bus_addr == STAT_ADDR) sel = SEL_STAT;
    else                            sel = SEL_NONE;
  end

  tbcap_edge_det u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (hw_evt),
    .rise (hw_rise)
  );

  tbcap_hold_core #(.FLD_W(FW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .rd_clr (rd_cap),
    .cnt_hi (tb_count[CNT_W-1:LSB]),
    .flag   (flag),
    .hold   (hold)
  );

  tbcap_read_fmt #(
    .DATA_W   (DATA_W),
    .FLD_W    (FW),
    .LSB      (LSB),
    .STAT_BIT (tbcap_pkg::STAT_BIT)
  ) u_fmt (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .sel   (sel),
    .hold  (hold),
    .flag  (flag),
    .rdata (bus_rdata)
  );

  assign cap_flag = flag;

  // R3
  sw_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_flag && !hw_rise && !(bus_wr && bus_addr == CAP_ADDR && bus_wdata[0])) |=> !cap_flag);
  // R8
  one_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_flag && hw_rise && sw_req) |=> (cap_flag && hold == $past(tb_count[CNT_W-1:LSB])));
endmodule

// File: tb/tbcap_capture_reg_tb.sv
module tbcap_capture_reg_tb;
  localparam logic [3:0] CAPA = 4'h4;
  localparam logic [3:0] STATA = 4'h0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [19:0] tb_count = 20'h3A5C1;
  logic        hw_evt = 1'b0;
  logic        cap_flag;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  bit          m_flag = 0;
  logic [15:0] m_hold = '0;
  bit          m_prev = 0;
  logic [31:0] m_rd = '0;
  logic [19:0] snap;

  always #10 clk = ~clk;

  tbcap_capture_reg u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tb_count(tb_count), .hw_evt(hw_evt), .cap_flag(cap_flag)
  );

  always @(negedge clk) tb_count <= tb_count + 20'd7;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    bit rise, sw, rdc;
    logic [31:0] nrd;
    if (rst) begin
      m_flag = 0; m_hold = '0; m_prev = 0; m_rd = '0;
    end else begin
      rise = hw_evt && !m_prev;
      sw   = bus_wr && bus_addr == CAPA && bus_wdata[0];
      rdc  = bus_rd && bus_addr == CAPA;
      nrd  = '0;
      if (bus_rd) begin
        if (bus_addr == CAPA)       nrd = {12'h0, m_hold, 4'h0};
        else if (bus_addr == STATA) nrd = 32'(m_flag) << 5;
      end
      if (m_flag) begin
        if (rdc) m_flag = 0;
      end else if (rise || sw) begin
        m_flag = 1;
        m_hold = tb_count[19:4];
      end
      m_prev = hw_evt;
      m_rd   = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("model flag R6", {31'h0, cap_flag}, {31'h0, m_flag});
      check("model rdata R4", bus_rdata, m_rd);
    end
  end

  task automatic step(input bit hw, input bit wr, input bit rd,
                      input logic [3:0] a, input logic [31:0] wd);
    hw_evt = hw; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    snap = tb_count;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, STATA, 32'h0);
  endtask

  function automatic logic [31:0] cw(input logic [19:0] c);
    return {12'h0, c[19:4], 4'h0};
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 flag", {31'h0, cap_flag}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    step(0, 0, 1, CAPA, 0);
    check("R1 held", bus_rdata, 32'h0);
    idle(1);

    // R2 hardware pulse
    step(1, 0, 0, STATA, 0); v = snap;
    idle(1);
    check("R2 flag", {31'h0, cap_flag}, 32'h1);
    step(0, 0, 1, STATA, 0);
    check("R5 status", bus_rdata, 32'h20);
    check("R6 stat read keeps", {31'h0, cap_flag}, 32'h1);
    step(0, 0, 1, CAPA, 0);
    check("R4 word", bus_rdata, cw(v));
    check("R6 cleared", {31'h0, cap_flag}, 32'h0);
    idle(1);
    check("R4 idle zero", bus_rdata, 32'h0);
    step(0, 0, 1, STATA, 0);
    check("R5 status clear", bus_rdata, 32'h0);

    // R3 software
    step(0, 1, 0, CAPA, 32'hFFFF_FFFE);
    step(0, 1, 0, STATA, 32'h1);
    step(0, 1, 0, 4'h9, 32'h1);
    idle(1);
    check("R3 no effect", {31'h0, cap_flag}, 32'h0);
    step(0, 1, 0, CAPA, 32'h1); v = snap;
    idle(2);
    check("R3 flag", {31'h0, cap_flag}, 32'h1);

    // R7 lock
    step(1, 0, 0, STATA, 0);
    idle(1);
    step(0, 1, 0, CAPA, 32'h1);
    step(1, 1, 0, CAPA, 32'h3);
    idle(2);
    step(0, 0, 1, CAPA, 0);
    check("R7 held", bus_rdata, cw(v));
    check("R7 flag clr", {31'h0, cap_flag}, 32'h0);

    // R8 simultaneous
    step(1, 1, 0, CAPA, 32'h1); v = snap;
    idle(2);
    step(0, 0, 1, CAPA, 0);
    check("R8 single", bus_rdata, cw(v));
    idle(1);
    check("R8 no second", {31'h0, cap_flag}, 32'h0);

    // R9 collision while set
    step(0, 1, 0, CAPA, 32'h1); v = snap;
    idle(1);
    step(1, 0, 1, CAPA, 0);
    check("R9 read value", bus_rdata, cw(v));
    check("R9 flag clr", {31'h0, cap_flag}, 32'h0);
    idle(3);
    check("R9 dropped", {31'h0, cap_flag}, 32'h0);

    // R10 level held
    step(1, 0, 0, STATA, 0); v = snap;
    step(1, 0, 0, STATA, 0);
    step(1, 0, 1, CAPA, 0);
    check("R10 value", bus_rdata, cw(v));
    step(1, 0, 0, STATA, 0);
    step(1, 0, 0, STATA, 0);
    check("R10 no recapture", {31'h0, cap_flag}, 32'h0);
    idle(1);

    // R11 read + request while armed
    step(0, 1, 0, CAPA, 32'h1); v = snap;
    step(0, 0, 1, CAPA, 0);
    idle(1);
    step(0, 1, 1, CAPA, 32'h1); v2 = snap;
    check("R11 old value", bus_rdata, cw(v));
    check("R11 flag set", {31'h0, cap_flag}, 32'h1);
    step(0, 0, 1, CAPA, 0);
    check("R11 new value", bus_rdata, cw(v2));
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule